// File: doc/BRIEF.md
# Blank-Gated Palette Write Guard

This block sits between a CPU bus and a palette RAM. The CPU may write a palette entry only while the display is in vertical blanking. A palette write attempted outside that window never reaches the RAM. Instead it raises a sticky error flag that the CPU can inspect.

The guard also produces the cabinet status byte that the CPU reads. That byte merges six externally supplied cabinet input bits with the current blanking state and the inverted error flag. Software clears the flag by reading or writing any address that matches a partially decoded pattern, where one nibble is ignored.

The write enable and the status byte are combinational from the bus. The error flag is the only storage in the block, and it updates on the clock edge that ends the bus cycle.

Top module: `pal_guard`

## Requirements
- R1: `pal_we_o` is high in a cycle exactly when `cpu_wr_i`, `pal_sel_i` and `vblank_i` are all high; a palette write with `vblank_i` low leaves `pal_we_o` low.
- R2: A palette write (`cpu_wr_i` and `pal_sel_i`) with `vblank_i` low sets the error flag at the next rising clock edge. After that edge, status bit 2 reads 0.
- R3: Status bit 3 equals `vblank_i`, where 1 means blanking is in progress.
- R4: A read or a write whose address satisfies `(addr & 16'hFF0F) == 16'hC803` clears the error flag at the next edge, for every one of the 16 values of address bits 7:4. After the clear, status bit 2 reads 1.
- R5: Reads or writes at addresses that fail the R4 match leave the error flag unchanged.
- R6: The error flag stays set through later palette writes that succeed.
- R7: When a blocked write and a clear access occur in the same cycle, the error flag ends up set.
- R8: Status bits 7:4 equal `cab_i[5:2]` and status bits 1:0 equal `cab_i[1:0]`.
- R9: `status_o` carries the status byte only while `cpu_rd_i` is high and `cpu_addr_i` equals 16'hC000. At all other times it is 8'h00.
- R10: Synchronous reset clears the error flag, so status bit 2 reads 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_rd_i | input | 1 | CPU read strobe |
| pal_sel_i | input | 1 | Palette RAM select from the system decoder |
| vblank_i | input | 1 | Vertical blanking, high while blanking |
| cab_i | input | 6 | Cabinet inputs (coin, start and similar) |
| pal_we_o | output | 1 | Gated palette RAM write enable |
| status_o | output | 8 | Cabinet status byte for CPU reads |

## Verification
The bench sweeps all 16 values of the ignored nibble in the clear address. A decoder that compares too many bits would leave the flag stuck for some of those values. It also issues accesses at near-miss addresses, such as one with a wrong low nibble or a wrong upper byte. A decoder that masks too much would then clear the flag by accident.

The bench also collides a blocked write with a clear access in the same cycle, where a design that gives the clear priority would lose the error. It follows a blocked write with good writes, which exposes a flag that is not sticky. Finally, it places distinct patterns on the cabinet bits, so that an off-by-one field mapping or the wrong polarity on bits 2 and 3 shows up in the readback.

// File: rtl/pal_guard_pkg.sv
package pal_guard_pkg;
    localparam int ADDR_W    = 16;
    localparam int STAT_W    = 8;
    localparam int CAB_W     = 6;
    localparam logic [ADDR_W-1:0] CLR_MASK  = 16'hFF0F;
    localparam logic [ADDR_W-1:0] CLR_MATCH = 16'hC803;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 16'hC000;
    localparam int VBL_BIT = 3;
    localparam int ERR_BIT = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              rd;
        logic              sel;
    } bus_req_t;

    typedef struct packed {
        logic clr_hit;
        logic stat_hit;
    } dec_t;

    function automatic logic addr_matches(input logic [ADDR_W-1:0] a,
                                          input logic [ADDR_W-1:0] mask,
                                          input logic [ADDR_W-1:0] match);
        return (a & mask) == (match & mask);
    endfunction
endpackage

// File: rtl/pal_guard_decode.sv
module pal_guard_decode
    import pal_guard_pkg::*;
(
    input  bus_req_t req,
    output dec_t     dec
);
    always_comb begin
        dec.clr_hit  = (req.wr | req.rd) & addr_matches(req.addr, CLR_MASK, CLR_MATCH);
        dec.stat_hit = req.rd & (req.addr == STAT_ADDR);
    end
endmodule

// File: rtl/pal_guard_gate.sv
module pal_guard_gate
    import pal_guard_pkg::*;
(
    input  bus_req_t req,
    input  logic     vblank,
    output logic     we,
    output logic     blocked
);
    logic pal_write;
    always_comb begin
        pal_write = req.wr & req.sel;
        we        = pal_write & vblank;
        blocked   = pal_write & ~vblank;
    end
endmodule

// File: rtl/pal_guard_errflag.sv
module pal_guard_errflag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic err_o
);
    always_ff @(posedge clk) begin
        if (rst)        err_o <= 1'b0;
        else if (set_i) err_o <= 1'b1;
        else if (clr_i) err_o <= 1'b0;
    end
endmodule

// File: rtl/pal_guard_status.sv
module pal_guard_status
    import pal_guard_pkg::*;
(
    input  logic             en,
    input  logic             vblank,
    input  logic             err,
    input  logic [CAB_W-1:0] cab,
    output logic [STAT_W-1:0] status
);
    logic [STAT_W-1:0] raw;
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (i == VBL_BIT) begin : g_vbl
            assign raw[i] = vblank;
        end else if (i == ERR_BIT) begin : g_err
            assign raw[i] = ~err;
        end else if (i > VBL_BIT) begin : g_hi
            assign raw[i] = cab[i-2];
        end else begin : g_lo
            assign raw[i] = cab[i];
        end
    end
    assign status = en ? raw : '0;
endmodule

// File: rtl/pal_guard.sv
module pal_guard
    import pal_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic              cpu_wr_i,
    input  logic              cpu_rd_i,
    input  logic              pal_sel_i,
    input  logic              vblank_i,
    input  logic [CAB_W-1:0]  cab_i,
    output logic              pal_we_o,
    output logic [STAT_W-1:0] status_o
);
    bus_req_t req;
    dec_t     dec;
    logic     blocked;
    logic     err_q;

    assign req = '{addr: cpu_addr_i, wr: cpu_wr_i, rd: cpu_rd_i, sel: pal_sel_i};

    pal_guard_decode u_dec (.req(req), .dec(dec));

    pal_guard_gate u_gate (
        .req(req), .vblank(vblank_i), .we(pal_we_o), .blocked(blocked)
    );

    pal_guard_errflag u_err (
        .clk(clk), .rst(rst), .set_i(blocked), .clr_i(dec.clr_hit), .err_o(err_q)
    );

    pal_guard_status u_stat (
        .en(dec.stat_hit), .vblank(vblank_i), .err(err_q), .cab(cab_i), .status(status_o)
    );
endmodule

// File: rtl/pal_guard_chk.sv
module pal_guard_chk
    import pal_guard_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr_i,
    input logic              cpu_wr_i,
    input logic              cpu_rd_i,
    input logic              pal_sel_i,
    input logic              vblank_i,
    input logic              pal_we_o,
    input logic [STAT_W-1:0] status_o,
    input logic              err_q
);
    logic clr_acc, bad_wr;
    assign clr_acc = (cpu_wr_i | cpu_rd_i) && ((cpu_addr_i & 16'hFF0F) == 16'hC803);
    assign bad_wr  = cpu_wr_i && pal_sel_i && !vblank_i;

    assert_no_write_outside_blank_R1: assert property (@(posedge clk) disable iff (rst)
        !vblank_i |-> !pal_we_o);
    assert_blocked_sets_flag_R2: assert property (@(posedge clk) disable iff (rst)
        bad_wr |=> err_q);
    assert_clear_drops_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_acc && !bad_wr) |=> !err_q);
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (err_q && !clr_acc) |=> err_q);
    assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (bad_wr && clr_acc) |=> err_q);
    assert_idle_status_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !(cpu_rd_i && cpu_addr_i == 16'hC000) |-> status_o == 8'h00);
endmodule

bind pal_guard pal_guard_chk u_chk (
    .clk(clk), .rst(rst), .cpu_addr_i(cpu_addr_i), .cpu_wr_i(cpu_wr_i),
    .cpu_rd_i(cpu_rd_i), .pal_sel_i(pal_sel_i), .vblank_i(vblank_i),
    .pal_we_o(pal_we_o), .status_o(status_o), .err_q(err_q)
);

// File: tb/tb_pal_guard.sv
module tb_pal_guard;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr;
    logic        wr, rd, sel, vbl;
    logic [5:0]  cab;
    logic        we;
    logic [7:0]  status;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pal_guard dut (
        .clk(clk), .rst(rst), .cpu_addr_i(addr), .cpu_wr_i(wr), .cpu_rd_i(rd),
        .pal_sel_i(sel), .vblank_i(vbl), .cab_i(cab), .pal_we_o(we), .status_o(status)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one bus cycle at the falling edge, then let the rising edge pass
    task automatic cycle(input logic [15:0] a, input logic w, input logic r, input logic s);
        @(negedge clk);
        addr = a; wr = w; rd = r; sel = s;
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        addr = 16'h0000; wr = 0; rd = 0; sel = 0;
    endtask

    // returns the error bit as seen through a status read
    task automatic read_err(output logic e);
        @(negedge clk);
        addr = 16'hC000; rd = 1; wr = 0; sel = 0;
        #1 e = status[2];
        @(posedge clk);
        idle();
    endtask

    task automatic t_reset();
        logic e;
        rst = 1; addr = 0; wr = 0; rd = 0; sel = 0; vbl = 0; cab = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        read_err(e);
        check("R10 error clear after reset", {7'd0, e}, 8'd1);
    endtask

    task automatic t_gate();
        @(negedge clk);
        vbl = 1; addr = 16'h8000; wr = 1; sel = 1;
        #1 check("R1 write in blank passes", {7'd0, we}, 8'd1);
        sel = 0;
        #1 check("R1 no select no enable", {7'd0, we}, 8'd0);
        wr = 0; sel = 1;
        #1 check("R1 no strobe no enable", {7'd0, we}, 8'd0);
        wr = 1; vbl = 0;
        #1 check("R1 write outside blank blocked", {7'd0, we}, 8'd0);
        wr = 0; sel = 0;
        @(posedge clk);
        idle();
    endtask

    task automatic t_set_and_sticky();
        logic e;
        vbl = 0;
        cycle(16'h8010, 1, 0, 1);
        idle();
        read_err(e);
        check("R2 blocked write sets flag", {7'd0, e}, 8'd0);
        vbl = 1;
        cycle(16'h8011, 1, 0, 1);
        cycle(16'h8012, 1, 0, 1);
        idle();
        read_err(e);
        check("R6 flag sticky over good writes", {7'd0, e}, 8'd0);
    endtask

    task automatic t_clear_all_nibbles();
        logic e;
        for (int n = 0; n < 16; n++) begin
            vbl = 0;
            cycle(16'h8000, 1, 0, 1);
            idle();
            // alternate read and write accesses for the clear
            cycle(16'hC803 | (16'(n) << 4), n[0], ~n[0], 0);
            idle();
            read_err(e);
            check($sformatf("R4 clear with nibble %0d", n), {7'd0, e}, 8'd1);
        end
    endtask

    task automatic t_clear_other();
        logic e;
        logic [15:0] miss [5] = '{16'hC802, 16'hC80B, 16'hC903, 16'h4803, 16'hD8F3};
        vbl = 0;
        cycle(16'h8000, 1, 0, 1);
        idle();
        foreach (miss[i]) begin
            cycle(miss[i], 0, 1, 0);
            cycle(miss[i], 1, 0, 0);
        end
        idle();
        read_err(e);
        check("R5 non-matching accesses keep flag", {7'd0, e}, 8'd0);
        cycle(16'hC8A3, 0, 1, 0);
        idle();
    endtask

    task automatic t_priority();
        logic e;
        vbl = 0;
        cycle(16'hC853, 1, 0, 1);
        idle();
        read_err(e);
        check("R7 set wins over clear", {7'd0, e}, 8'd0);
        cycle(16'hC803, 0, 1, 0);
        idle();
        read_err(e);
        check("R4 clear after collision", {7'd0, e}, 8'd1);
    endtask

    task automatic t_status_fields();
        @(negedge clk);
        cab = 6'b101101; vbl = 1; addr = 16'hC000; rd = 1; wr = 0; sel = 0;
        #1 check("R8 R3 status byte pattern A", status, {4'b1011, 1'b1, 1'b1, 2'b01});
        cab = 6'b010010; vbl = 0;
        #1 check("R8 R3 status byte pattern B", status, {4'b0100, 1'b0, 1'b1, 2'b10});
        addr = 16'hC001;
        #1 check("R9 wrong address gives zero", status, 8'h00);
        addr = 16'hC000; rd = 0;
        #1 check("R9 no read gives zero", status, 8'h00);
        @(posedge clk);
        idle();
    endtask

    initial begin
        t_reset();
        t_gate();
        t_set_and_sticky();
        t_clear_all_nibbles();
        t_clear_other();
        t_priority();
        t_status_fields();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule